// File: doc/BRIEF.md
# E1 Channel-Associated Signaling Extractor

This block sits behind the framer of an E1 receiver. Each clock it takes one bit of the received stream, together with that bit's position: the timeslot, the bit within the timeslot and the frame within the signaling multiframe. Frame and multiframe alignment are already done upstream. In frames 1 to 15, timeslot 16 carries two four-bit signaling words. The upper nibble belongs to the timeslot whose number equals the frame number. The lower nibble belongs to the timeslot sixteen higher. Frame 0 is not used for signaling.

The block keeps one stored ABCD word for each of the 30 voice timeslots. A stored word changes only when extraction is enabled for that timeslot. With debounce on, a new word must also be received twice in a row. No change is made while the block is frozen by alignment loss, a slip, or a freeze request. Each change sets a sticky per-timeslot flag, and the flags can raise an interrupt. The stored words are sent back out on a serial signaling line, aligned with a one-clock-delayed copy of the data. Software reaches the per-timeslot state through a small indirect access port.

Top module: `e1_cas_extract`

## Requirements
- R1: After reset, every stored ABCD word is 0000, extraction is disabled in every timeslot, all change flags are clear, `irq` is low and `ind_busy` is low.
- R2: At the last bit (`rx_pos`=7) of timeslot 16 in frame n, for n from 1 to 15, the received byte is taken MSB first (`rx_pos`=0 first). Its upper nibble is the candidate word for timeslot n and its lower nibble is the candidate word for timeslot n+16. Timeslot 16 of frame 0 yields no words.
- R3: A timeslot whose extract-enable bit is 0 keeps its stored word, whatever it receives.
- R4: With `deb_en` high, a candidate is stored only if it equals the previous candidate received for that timeslot. The previous candidate is recorded at each reception while not frozen, whether or not extraction is enabled.
- R5: While any of `los_frame`, `los_mframe`, `slip` or `freeze_req` is high, no stored word and no previous candidate changes.
- R6: `data_out` is `rx_bit` delayed by one clock. One clock after a bit with `rx_pos` 4, 5, 6 or 7 is presented in timeslot t, `sig_out` carries bit A, B, C or D of t's stored word, in that order, where A is the word's bit 3. `sig_out` is don't-care for timeslots 0 and 16.
- R7: A change of a stored word sets that timeslot's change flag, and the flag stays set until cleared. Flag register 0x20+k holds, in bit i, the flag of timeslot 8k+i. Writing 1 to a bit clears that flag and writing 0 leaves it unchanged. If a set and a clear happen together, the set wins.
- R8: `irq` is high exactly when `sig_ie` is high and at least one change flag is set.
- R9: An access is accepted on `ind_req` while `ind_busy` is low. `ind_busy` is then high for exactly one clock, and `ind_rdata` is valid once it falls. Addresses 1 to 15 and 17 to 31 select a timeslot register. Its bit 7 is the extract enable, which can be read and written. Its bits 3:0 are the stored word, which is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Received serial data bit |
| rx_ts | input | 5 | Timeslot number of the current bit |
| rx_pos | input | 3 | Bit position within the timeslot, 0 = first |
| rx_frame | input | 4 | Frame number within the signaling multiframe |
| los_frame | input | 1 | Loss of basic frame alignment |
| los_mframe | input | 1 | Loss of signaling multiframe alignment |
| slip | input | 1 | Slip indication from the elastic buffer |
| freeze_req | input | 1 | Freeze request from control |
| deb_en | input | 1 | Debounce enable |
| sig_ie | input | 1 | Signaling interrupt enable |
| ind_req | input | 1 | Indirect access request |
| ind_rnw | input | 1 | 1 = read, 0 = write |
| ind_addr | input | 7 | Indirect register address |
| ind_wdata | input | 8 | Indirect write data |
| ind_busy | output | 1 | Access in progress |
| ind_rdata | output | 8 | Indirect read data |
| data_out | output | 1 | Delayed data stream |
| sig_out | output | 1 | Serial signaling stream |
| irq | output | 1 | Signaling change interrupt |

## Verification
The in-line properties check on every cycle that a freeze holds all stored words and that a disabled timeslot's word never moves. They also check that every change of a stored word leaves its flag set, and that the busy pulse lasts a single clock. Only the bench's scenarios can show the rest. These are the nibble-to-timeslot mapping, debounce that needs two matching words, the bit order and alignment of the serial signaling output, the four freeze sources, partial flag clearing, and interrupt gating. The bench drives complete multiframes and compares them with its own model.

// File: rtl/e1_cas_extract.sv
module e1_cas_extract (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  input  logic [4:0] rx_ts,
  input  logic [2:0] rx_pos,
  input  logic [3:0] rx_frame,
  input  logic       los_frame,
  input  logic       los_mframe,
  input  logic       slip,
  input  logic       freeze_req,
  input  logic       deb_en,
  input  logic       sig_ie,
  input  logic       ind_req,
  input  logic       ind_rnw,
  input  logic [6:0] ind_addr,
  input  logic [7:0] ind_wdata,
  output logic       ind_busy,
  output logic [7:0] ind_rdata,
  output logic       data_out,
  output logic       sig_out,
  output logic       irq
);
  localparam int NTS = 32;

  logic [NTS-1:0][3:0] sig_q, prev_q;
  logic [NTS-1:0]      en_q, flag_q, rcv, upd, clr;
  logic [6:0]          sh_q, a_q;
  logic                rnw_q;
  logic [7:0]          wd_q;
  logic [7:0]          rx_byte;
  logic                frozen, byte_done, wr_ts, wr_flag;

  assign frozen    = los_frame | los_mframe | slip | freeze_req;
  assign rx_byte   = {sh_q, rx_bit};
  assign byte_done = (rx_ts == 5'd16) && (rx_pos == 3'd7) && (rx_frame != 4'd0);
  assign wr_ts     = ind_busy && !rnw_q && (a_q[6:5] == 2'b00) && (a_q[3:0] != 4'd0);
  assign wr_flag   = ind_busy && !rnw_q && (a_q[6:2] == 5'b01000);
  assign clr       = wr_flag ? (NTS'(wd_q) << {a_q[1:0], 3'b000}) : '0;
  assign irq       = sig_ie && (flag_q != '0);

  for (genvar g = 0; g < NTS; g++) begin : g_ts
    localparam logic [4:0] TS = 5'(g);
    logic [3:0] code;
    assign code   = TS[4] ? rx_byte[3:0] : rx_byte[7:4];
    assign rcv[g] = byte_done && !frozen && (TS == {TS[4], rx_frame});
    assign upd[g] = rcv[g] && en_q[g] && (!deb_en || code == prev_q[g]) && (code != sig_q[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sig_q[g]  <= '0;
        prev_q[g] <= '0;
        en_q[g]   <= 1'b0;
        flag_q[g] <= 1'b0;
      end else begin
        if (rcv[g]) prev_q[g] <= code;
        if (upd[g]) sig_q[g] <= code;
        flag_q[g] <= (flag_q[g] & ~clr[g]) | upd[g];
        if (wr_ts && a_q[4:0] == TS) en_q[g] <= wd_q[7];
      end
    end

    p_hold_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[g] |=> $stable(sig_q[g]));
    p_flag_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sig_q[g]) |-> flag_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      data_out  <= 1'b0;
      sig_out   <= 1'b0;
      ind_busy  <= 1'b0;
      ind_rdata <= '0;
      a_q       <= '0;
      rnw_q     <= 1'b0;
      wd_q      <= '0;
    end else begin
      sh_q     <= rx_byte[6:0];
      data_out <= rx_bit;
      sig_out  <= (rx_pos[2] && rx_ts[3:0] != 4'd0) ? sig_q[rx_ts][~rx_pos[1:0]] : 1'b0;
      if (ind_busy) begin
        ind_busy <= 1'b0;
        if (a_q[6:5] == 2'b00)
          ind_rdata <= {en_q[a_q[4:0]], 3'b000, sig_q[a_q[4:0]]};
        else if (a_q[6:2] == 5'b01000)
          ind_rdata <= flag_q[{a_q[1:0], 3'b000} +: 8];
        else
          ind_rdata <= '0;
      end else if (ind_req) begin
        ind_busy <= 1'b1;
        a_q      <= ind_addr;
        rnw_q    <= ind_rnw;
        wd_q     <= ind_wdata;
      end
    end
  end

  p_freeze_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> ($stable(sig_q) && $stable(prev_q)));
  p_busy_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ind_busy |=> !ind_busy);
endmodule

// File: tb/e1_cas_extract_bench.sv
module e1_cas_extract_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_bit = 0, los_frame = 0, los_mframe = 0, slip = 0, freeze_req = 0;
  logic deb_en = 0, sig_ie = 1, ind_req = 0, ind_rnw = 0;
  logic [4:0] rx_ts = 0;
  logic [2:0] rx_pos = 0;
  logic [3:0] rx_frame = 0;
  logic [6:0] ind_addr = 0;
  logic [7:0] ind_wdata = 0;
  logic ind_busy, data_out, sig_out, irq;
  logic [7:0] ind_rdata;

  e1_cas_extract u_e1_cas_extract (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, ser_err = 0;
  logic [3:0] m_sig [32], m_prev [32];
  logic m_en [32], m_flag [32];
  logic busy_seen;

  // row: [7] debounce, [6:5] freeze source (0 none,1 frame,2 mframe,3 slip), [4] enable, [3:0] seed
  localparam logic [7:0] VEC [8] = '{8'h15, 8'h99, 8'h99, 8'h33, 8'h53, 8'h73, 8'h0C, 8'h1C};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] code_of(input logic [3:0] seed, input int t);
    logic [4:0] tv = 5'(t);
    return seed ^ tv[3:0] ^ {tv[4], tv[4], 2'b00};
  endfunction

  task automatic ind_acc(input logic rnw, input logic [6:0] a, input logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk); ind_req = 1; ind_rnw = rnw; ind_addr = a; ind_wdata = wd;
    @(negedge clk); ind_req = 0; busy_seen = ind_busy;
    @(negedge clk); rd = ind_rdata;
  endtask

  task automatic model_rx(input int t, input logic [3:0] c, input logic frz);
    if (!frz) begin
      if (m_en[t] && (!deb_en || c == m_prev[t]) && c != m_sig[t]) begin
        m_sig[t] = c; m_flag[t] = 1;
      end
      m_prev[t] = c;
    end
  endtask

  task automatic step(input logic b, input int ts, input int bp, input int fr);
    @(negedge clk); rx_bit = b; rx_ts = 5'(ts); rx_pos = 3'(bp); rx_frame = 4'(fr);
    @(posedge clk); #1;
    if (data_out !== b) ser_err++;
    if (bp >= 4 && ts != 0 && ts != 16 && sig_out !== m_sig[ts][7-bp]) ser_err++;
  endtask

  task automatic send_mf(input logic [3:0] seed, input logic frz);
    ser_err = 0;
    for (int fr = 0; fr < 16; fr++)
      for (int ts = 0; ts < 32; ts++) begin
        logic [7:0] by = {code_of(seed, fr), code_of(seed, fr + 16)};
        for (int bp = 0; bp < 8; bp++) begin
          logic b = (ts == 16) ? ((fr == 0) ? 1'b1 : by[7-bp]) : ^{4'(fr), 5'(ts), 3'(bp)};
          step(b, ts, bp, fr);
        end
        if (ts == 16 && fr != 0) begin
          model_rx(fr, by[7:4], frz);
          model_rx(fr + 16, by[3:0], frz);
        end
      end
    check("R6 serial data/signaling mismatches", ser_err, 0);
  endtask

  task automatic set_en_all(input logic v);
    logic [7:0] rd;
    for (int t = 1; t < 32; t++)
      if (t != 16) begin ind_acc(0, 7'(t), {v, 7'b0}, rd); m_en[t] = v; end
  endtask

  task automatic check_words(input string req);
    logic [7:0] rd;
    for (int t = 1; t < 32; t++)
      if (t != 16) begin
        ind_acc(1, 7'(t), 8'h00, rd);
        check(req, rd, {m_en[t], 3'b000, m_sig[t]});
      end
  endtask

  task automatic check_flags(input string req);
    logic [7:0] rd;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] e;
      for (int i = 0; i < 8; i++) e[i] = m_flag[8*k+i];
      ind_acc(1, 7'(32 + k), 8'h00, rd);
      check(req, rd, e);
    end
  endtask

  task automatic clear_flags;
    logic [7:0] rd;
    for (int k = 0; k < 4; k++) ind_acc(0, 7'(32 + k), 8'hFF, rd);
    for (int t = 0; t < 32; t++) m_flag[t] = 0;
  endtask

  function automatic logic any_flag();
    for (int t = 0; t < 32; t++) if (m_flag[t]) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    #(4 * 190000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    for (int t = 0; t < 32; t++) begin m_sig[t] = 0; m_prev[t] = 0; m_en[t] = 0; m_flag[t] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy after reset", ind_busy, 0);
    check("R1 irq after reset", irq, 0);
    check_words("R1 reset word/enable");
    check_flags("R1 reset flags");
    ind_acc(1, 7'd1, 8'h00, rd);
    check("R9 busy high during access", busy_seen, 1);
    check("R9 busy one clock", ind_busy, 0);

    for (int r = 0; r < 8; r++) begin
      logic [7:0] v = VEC[r];
      set_en_all(v[4]);
      deb_en = v[7];
      los_frame = (v[6:5] == 2'd1); los_mframe = (v[6:5] == 2'd2); slip = (v[6:5] == 2'd3);
      send_mf(v[3:0], v[6:5] != 2'd0);
      los_frame = 0; los_mframe = 0; slip = 0;
      check_words("R2/R3/R4/R5 stored words");
      check_flags("R7 flags");
      @(negedge clk);
      check("R8 irq with enable", irq, any_flag());
      if (r == 0) begin
        sig_ie = 0; @(negedge clk);
        check("R8 irq masked", irq, 0);
        sig_ie = 1;
      end
      clear_flags();
      @(negedge clk);
      check("R8 irq after clear", irq, 0);
    end

    // freeze request
    deb_en = 0; freeze_req = 1;
    send_mf(4'h6, 1'b1);
    freeze_req = 0;
    check_words("R5 freeze request holds");
    check_flags("R5 no flags while frozen");

    // partial write-one-to-clear
    send_mf(4'h6, 1'b0);
    check_words("R2 update after freeze");
    ind_acc(1, 7'h20, 8'h00, rd);
    check("R7 flag byte 0", rd, {m_flag[7], m_flag[6], m_flag[5], m_flag[4], m_flag[3], m_flag[2], m_flag[1], 1'b0});
    ind_acc(0, 7'h20, 8'h02, rd);
    m_flag[1] = 0;
    check_flags("R7 partial clear");
    @(negedge clk);
    check("R8 irq still set", irq, 1);
    clear_flags();
    @(negedge clk);
    check("R8 irq cleared", irq, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule